// File: doc/BRIEF.md
# Three-Channel Timer Register Front End

This block is the byte-wide programming and readback face of a three-channel 16-bit timer. A host sees four byte addresses: one data port per channel at addresses 0, 1 and 2, and a command port at address 3. Command bytes pick, for each channel, how its 16-bit values cross the 8-bit bus (low byte alone, high byte alone, or low byte then high byte). They also set the channel's operating mode and its binary/BCD flag. Further command codes freeze a channel's count, or a status byte describing it, so that software can read a consistent value while the channel keeps counting.

The counting engines are outside this block. Each channel supplies its live count, its output level and its count-loaded flag as inputs. In return the block hands each channel an assembled 16-bit load value with a one-cycle load strobe, together with the programmed mode and BCD flag.

Top module: `tmr_cmd_frontend`

## Requirements
- R1: After reset every channel uses low-then-high access, mode 0 and binary counting, with no value frozen. A data-port read then returns the live count's low byte, and the next read returns its high byte.
- R2: In a command byte, bits 7-4 are the command, bits 3-1 the mode and bit 0 the BCD flag. Commands 4n+1, 4n+2 and 4n+3 (n = channel 0..2) select low-only, high-only and low-then-high access for channel n. They also store the mode and BCD flag, restart both byte pointers and drop any frozen value.
- R3: In low-only access a data-port write loads {8'h00, data}. `ch_load_stb` for that channel is high in the cycle after the write edge.
- R4: In high-only access a data-port write loads {data, 8'h00} with the same strobe timing.
- R5: In low-then-high access the first write only stores the low byte and gives no strobe. The second write loads {second, first} and gives the strobe.
- R6: Command 4n+0 freezes channel n's count, and the mode and BCD bits of that command are ignored. Reads return the frozen value even while the live count moves. The freeze ends after one read in a single-byte access mode, or after two reads in low-then-high access.
- R7: A count-freeze command aimed at a channel whose count is already frozen and not yet fully read has no effect.
- R8: Command 1101 freezes the count of every channel whose select bit is set: bit 1 for channel 0, bit 2 for channel 1, bit 3 for channel 2.
- R9: Command 1110 freezes a status byte for each selected channel, using the same bit map. The status byte is {output level, loaded flag, access code, mode, BCD}, where the access code is 01 for high only, 10 for low only and 11 for both. A frozen status is read before a frozen count, and is itself held against later status commands until read.
- R10: In single-byte access, a read returns the selected byte of the frozen count, or of the live count when nothing is frozen.
- R11: Commands 1100 and 1111 change nothing. A read of the command port returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Byte address: 0..2 data ports, 3 command port |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte; read side effects take place at the edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the addressed port |
| ch_count | input | 48 | Live count of each channel, channel n at bits 16n+15:16n |
| ch_out | input | 3 | Output level of each channel |
| ch_loaded | input | 3 | Count-loaded flag of each channel |
| ch_load_val | output | 48 | Assembled load value, channel n at bits 16n+15:16n |
| ch_load_stb | output | 3 | One-cycle load strobe per channel |
| ch_mode | output | 9 | Programmed mode, channel n at bits 3n+2:3n |
| ch_bcd | output | 3 | Programmed BCD flag per channel |

## Verification
The hardest case to reach is a frozen status and a frozen count on the same channel while its live count and output level keep moving. Only that case shows whether the read order, the hold against repeated commands and the release all work together. The stimulus programs a channel, freezes its status and then its count, and issues a second status command after changing the output level. It then clears the live inputs and reads twice, so that each returned byte can only have come from the matching frozen copy. The group-freeze command is also driven with a select pattern that skips the middle channel, which shows the bit-to-channel mapping at the data ports.

// File: rtl/tmr_cmd_pkg.sv
// Shared constants and types for the timer register front end.
// Assumes a 16-bit count carried over an 8-bit bus in two bytes.
package tmr_cmd_pkg;
    localparam int N_CH = 3;
    localparam int BW   = 8;
    localparam int CW   = 2 * BW;
    localparam int MW   = 3;

    localparam logic [1:0] ADDR_CMD = 2'd3;

    localparam logic [3:0] OP_GROUP_CNT  = 4'hD;
    localparam logic [3:0] OP_GROUP_STAT = 4'hE;
    localparam logic [3:0] OP_FIRST_FREE = 4'hC;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_HI   = 2'b01,
        ACC_LO   = 2'b10,
        ACC_BOTH = 2'b11
    } acc_e;
endpackage

// File: rtl/tmr_cmd_decode.sv
// Command byte decoder. Turns one command-port write into per-channel
// requests: freeze count, freeze status or reprogram. Purely combinational;
// assumes at most one command write per cycle.
module tmr_cmd_decode
    import tmr_cmd_pkg::*;
(
    input  logic              cmd_wr,
    input  logic [BW-1:0]     cmd_byte,
    output logic [N_CH-1:0]   lat_cnt,
    output logic [N_CH-1:0]   lat_st,
    output logic [N_CH-1:0]   prog,
    output acc_e              prog_acc,
    output logic [MW-1:0]     prog_mode,
    output logic              prog_bcd
);
    logic [3:0] op;

    assign op        = cmd_byte[7:4];
    assign prog_mode = cmd_byte[3:1];
    assign prog_bcd  = cmd_byte[0];

    // Access code implied by the low two command bits.
    always_comb begin
        case (op[1:0])
            2'd1:    prog_acc = ACC_LO;
            2'd2:    prog_acc = ACC_HI;
            2'd3:    prog_acc = ACC_BOTH;
            default: prog_acc = ACC_NONE;
        endcase
    end

    // Per-channel request fan-out.
    always_comb begin
        lat_cnt = '0;
        lat_st  = '0;
        prog    = '0;
        if (cmd_wr) begin
            for (int n = 0; n < N_CH; n++) begin
                if (op < OP_FIRST_FREE && op[3:2] == 2'(n)) begin
                    if (op[1:0] == 2'd0) lat_cnt[n] = 1'b1;
                    else                 prog[n]    = 1'b1;
                end
                if (op == OP_GROUP_CNT  && cmd_byte[1+n]) lat_cnt[n] = 1'b1;
                if (op == OP_GROUP_STAT && cmd_byte[1+n]) lat_st[n]  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_chan_port.sv
// One channel's data port: access mode, write assembly, count and status
// freeze registers and read byte selection. Assumes read and write
// strobes are already qualified by this channel's address.
module tmr_chan_port
    import tmr_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic [BW-1:0]    wdata,
    input  logic             lat_cnt,
    input  logic             lat_st,
    input  logic             prog,
    input  acc_e             prog_acc,
    input  logic [MW-1:0]    prog_mode,
    input  logic             prog_bcd,
    input  logic [CW-1:0]    cnt_in,
    input  logic             out_in,
    input  logic             loaded_in,
    output logic [BW-1:0]    rdata,
    output logic [CW-1:0]    load_val,
    output logic             load_stb,
    output logic [MW-1:0]    mode,
    output logic             bcd,
    output acc_e             acc,
    output logic             cnt_held
);
    logic [CW-1:0] cnt_frz;
    logic [BW-1:0] st_frz;
    logic          st_held;
    logic [BW-1:0] lo_keep;
    logic          wr_ptr;
    logic          rd_ptr;
    logic [CW-1:0] cnt_src;
    logic [BW-1:0] st_now;

    assign st_now  = {out_in, loaded_in, acc, mode, bcd};
    assign cnt_src = cnt_held ? cnt_frz : cnt_in;

    // Read byte: frozen status first, then the selected count byte.
    always_comb begin
        if (st_held) begin
            rdata = st_frz;
        end else begin
            case (acc)
                ACC_HI:   rdata = cnt_src[CW-1:BW];
                ACC_BOTH: rdata = rd_ptr ? cnt_src[CW-1:BW] : cnt_src[BW-1:0];
                default:  rdata = cnt_src[BW-1:0];
            endcase
        end
    end

    // Configuration, pointers, freeze registers and load assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= ACC_BOTH;
            mode     <= '0;
            bcd      <= 1'b0;
            cnt_frz  <= '0;
            cnt_held <= 1'b0;
            st_frz   <= '0;
            st_held  <= 1'b0;
            lo_keep  <= '0;
            wr_ptr   <= 1'b0;
            rd_ptr   <= 1'b0;
            load_val <= '0;
            load_stb <= 1'b0;
        end else begin
            load_stb <= 1'b0;
            if (rd_stb) begin
                if (st_held) begin
                    st_held <= 1'b0;
                end else if (acc == ACC_BOTH) begin
                    rd_ptr <= ~rd_ptr;
                    if (rd_ptr) cnt_held <= 1'b0;
                end else begin
                    cnt_held <= 1'b0;
                end
            end
            if (wr_stb) begin
                case (acc)
                    ACC_LO: begin
                        load_val <= {{BW{1'b0}}, wdata};
                        load_stb <= 1'b1;
                    end
                    ACC_HI: begin
                        load_val <= {wdata, {BW{1'b0}}};
                        load_stb <= 1'b1;
                    end
                    ACC_BOTH: begin
                        if (!wr_ptr) begin
                            lo_keep <= wdata;
                            wr_ptr  <= 1'b1;
                        end else begin
                            load_val <= {wdata, lo_keep};
                            load_stb <= 1'b1;
                            wr_ptr   <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            if (lat_cnt && !cnt_held) begin
                cnt_frz  <= cnt_in;
                cnt_held <= 1'b1;
            end
            if (lat_st && !st_held) begin
                st_frz  <= st_now;
                st_held <= 1'b1;
            end
            if (prog) begin
                acc      <= prog_acc;
                mode     <= prog_mode;
                bcd      <= prog_bcd;
                cnt_held <= 1'b0;
                st_held  <= 1'b0;
                wr_ptr   <= 1'b0;
                rd_ptr   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tmr_cmd_frontend.sv
// Top of the timer register front end: address decode, command decoder
// and one data-port slice per channel. Assumes single-cycle bus strobes.
module tmr_cmd_frontend
    import tmr_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [BW-1:0]      bus_wdata,
    output logic [BW-1:0]      bus_rdata,
    input  logic [N_CH*CW-1:0] ch_count,
    input  logic [N_CH-1:0]    ch_out,
    input  logic [N_CH-1:0]    ch_loaded,
    output logic [N_CH*CW-1:0] ch_load_val,
    output logic [N_CH-1:0]    ch_load_stb,
    output logic [N_CH*MW-1:0] ch_mode,
    output logic [N_CH-1:0]    ch_bcd
);
    logic [N_CH-1:0]   lat_cnt;
    logic [N_CH-1:0]   lat_st;
    logic [N_CH-1:0]   prog_vec;
    acc_e              prog_acc;
    logic [MW-1:0]     prog_mode;
    logic              prog_bcd;
    logic [BW-1:0]     port_rd [N_CH];
    logic [2*N_CH-1:0] acc_vec;
    logic [N_CH-1:0]   held_vec;

    tmr_cmd_decode u_dec (
        .cmd_wr    (bus_wr && bus_addr == ADDR_CMD),
        .cmd_byte  (bus_wdata),
        .lat_cnt   (lat_cnt),
        .lat_st    (lat_st),
        .prog      (prog_vec),
        .prog_acc  (prog_acc),
        .prog_mode (prog_mode),
        .prog_bcd  (prog_bcd)
    );

    for (genvar n = 0; n < N_CH; n++) begin : g_ch
        acc_e acc_n;
        tmr_chan_port u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_stb    (bus_wr && bus_addr == 2'(n)),
            .rd_stb    (bus_rd && bus_addr == 2'(n)),
            .wdata     (bus_wdata),
            .lat_cnt   (lat_cnt[n]),
            .lat_st    (lat_st[n]),
            .prog      (prog_vec[n]),
            .prog_acc  (prog_acc),
            .prog_mode (prog_mode),
            .prog_bcd  (prog_bcd),
            .cnt_in    (ch_count[n*CW +: CW]),
            .out_in    (ch_out[n]),
            .loaded_in (ch_loaded[n]),
            .rdata     (port_rd[n]),
            .load_val  (ch_load_val[n*CW +: CW]),
            .load_stb  (ch_load_stb[n]),
            .mode      (ch_mode[n*MW +: MW]),
            .bcd       (ch_bcd[n]),
            .acc       (acc_n),
            .cnt_held  (held_vec[n])
        );
        assign acc_vec[2*n +: 2] = acc_n;
    end

    // Read data from the addressed data port; the command port reads zero.
    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < N_CH; n++)
            if (bus_addr == 2'(n)) bus_rdata = port_rd[n];
    end
endmodule

// File: rtl/tmr_cmd_frontend_chk.sv
// Checker for the timer register front end, bound into the top.
// Assumes it observes the top's ports plus the per-channel access codes,
// freeze flags and reprogram requests.
module tmr_cmd_frontend_chk
    import tmr_cmd_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [BW-1:0]      bus_rdata,
    input logic [N_CH*CW-1:0] ch_load_val,
    input logic [N_CH-1:0]    ch_load_stb,
    input logic [2*N_CH-1:0]  acc_vec,
    input logic [N_CH-1:0]    held_vec,
    input logic [N_CH-1:0]    prog_vec
);
    for (genvar n = 0; n < N_CH; n++) begin : g_a
        // R3 / R5: a strobe always follows a write to this channel's port.
        a_r5_stb_after_write: assert property (@(posedge clk) disable iff (!rst_n)
            ch_load_stb[n] |-> $past(bus_wr && bus_addr == 2'(n)));
        // R3: low-only loads carry a zero high byte.
        a_r3_lo_only_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_load_stb[n] && acc_vec[2*n +: 2] == ACC_LO)
                |-> ch_load_val[n*CW+BW +: BW] == '0);
        // R4: high-only loads carry a zero low byte.
        a_r4_hi_only_lo_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_load_stb[n] && acc_vec[2*n +: 2] == ACC_HI)
                |-> ch_load_val[n*CW +: BW] == '0);
        // R7: a frozen count stays frozen until a read or a reprogram.
        a_r7_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (held_vec[n] && !(bus_rd && bus_addr == 2'(n)) && !prog_vec[n])
                |=> held_vec[n]);
    end

    // R11: the command port reads as zero.
    a_r11_cmd_port_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_CMD |-> bus_rdata == '0);
endmodule

bind tmr_cmd_frontend tmr_cmd_frontend_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .ch_load_val (ch_load_val),
    .ch_load_stb (ch_load_stb),
    .acc_vec     (acc_vec),
    .held_vec    (held_vec),
    .prog_vec    (prog_vec)
);

// File: tb/sim_tmr_cmd_frontend.sv
// Directed bench for the timer register front end.
module sim_tmr_cmd_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] ch_count = '0;
    logic [2:0]  ch_out = '0;
    logic [2:0]  ch_loaded = '0;
    logic [47:0] ch_load_val;
    logic [2:0]  ch_load_stb;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_cmd_frontend u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_count(ch_count), .ch_out(ch_out), .ch_loaded(ch_loaded),
        .ch_load_val(ch_load_val), .ch_load_stb(ch_load_stb),
        .ch_mode(ch_mode), .ch_bcd(ch_bcd)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 mode", 16'(ch_mode), 16'h0);
        chk("R1 bcd", 16'(ch_bcd), 16'h0);
        chk("R1 stb", 16'(ch_load_stb), 16'h0);
        ch_count[15:0] = 16'h1234;
        rd(2'd0, d); chk("R1 first byte low", 16'(d), 16'h34);
        rd(2'd0, d); chk("R1 second byte high", 16'(d), 16'h12);
    endtask

    task automatic t_program();
        logic [7:0] d;
        wr(2'd3, 8'h54);
        wr(2'd3, 8'hA7);
        wr(2'd3, 8'h30);
        chk("R2 modes", 16'(ch_mode), 16'(9'b011_010_000));
        chk("R2 bcd", 16'(ch_bcd), 16'(3'b100));
        ch_count[31:16] = 16'h5678;
        ch_count[47:32] = 16'h9ABC;
        rd(2'd1, d); chk("R10 low-only live read", 16'(d), 16'h78);
        rd(2'd2, d); chk("R10 high-only live read", 16'(d), 16'h9A);
    endtask

    task automatic t_writes();
        wr(2'd1, 8'hAB);
        chk("R3 strobe", 16'(ch_load_stb), 16'(3'b010));
        chk("R3 value", ch_load_val[31:16], 16'h00AB);
        wr(2'd2, 8'hCD);
        chk("R4 strobe", 16'(ch_load_stb), 16'(3'b100));
        chk("R4 value", ch_load_val[47:32], 16'hCD00);
        wr(2'd0, 8'h11);
        chk("R5 no strobe after first byte", 16'(ch_load_stb), 16'h0);
        wr(2'd0, 8'h22);
        chk("R5 strobe", 16'(ch_load_stb), 16'(3'b001));
        chk("R5 value", ch_load_val[15:0], 16'h2211);
    endtask

    task automatic t_latch();
        logic [7:0] d;
        ch_count[15:0] = 16'hBEEF;
        wr(2'd3, 8'h0E);
        chk("R6 mode bits ignored", 16'(ch_mode[2:0]), 16'h0);
        ch_count[15:0] = 16'h1111;
        wr(2'd3, 8'h00);
        rd(2'd0, d); chk("R7 frozen low kept", 16'(d), 16'hEF);
        rd(2'd0, d); chk("R6 frozen high", 16'(d), 16'hBE);
        rd(2'd0, d); chk("R6 released low", 16'(d), 16'h11);
        rd(2'd0, d); chk("R6 released high", 16'(d), 16'h11);
    endtask

    task automatic t_group();
        logic [7:0] d;
        ch_count = {16'hC0C1, 16'hB0B1, 16'hA0A1};
        wr(2'd3, 8'hDA);
        ch_count = '0;
        rd(2'd0, d); chk("R8 ch0 low", 16'(d), 16'hA1);
        rd(2'd0, d); chk("R8 ch0 high", 16'(d), 16'hA0);
        rd(2'd2, d); chk("R8 ch2 high", 16'(d), 16'hC0);
        rd(2'd1, d); chk("R8 ch1 not selected", 16'(d), 16'h00);
    endtask

    task automatic t_status();
        logic [7:0] d;
        ch_out[1] = 1'b1; ch_loaded[1] = 1'b1;
        ch_count[31:16] = 16'h3344;
        wr(2'd3, 8'hE4);
        wr(2'd3, 8'h40);
        ch_out[1] = 1'b0; ch_loaded[1] = 1'b0;
        wr(2'd3, 8'hE4);
        ch_count[31:16] = 16'h0000;
        rd(2'd1, d); chk("R9 status first and held", 16'(d), 16'hE4);
        rd(2'd1, d); chk("R9 count after status", 16'(d), 16'h44);
        rd(2'd1, d); chk("R9 released", 16'(d), 16'h00);
    endtask

    task automatic t_ignored();
        logic [7:0] d;
        wr(2'd3, 8'hC0);
        wr(2'd3, 8'hFE);
        chk("R11 modes unchanged", 16'(ch_mode), 16'(9'b011_010_000));
        ch_count[15:0] = 16'h5A5A;
        rd(2'd0, d); chk("R11 ch0 not frozen", 16'(d), 16'h5A);
        rd(2'd3, d); chk("R11 command port reads zero", 16'(d), 16'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_writes();
        t_latch();
        t_group();
        t_status();
        t_ignored();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule